// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line back into characters. It is paced by a sampling enable that runs at sixteen times the bit rate. That enable is either a one-cycle pulse from an on-chip divider, or it comes from an external clock pin. The pin is brought into the core clock domain through a synchronizer, and each of its rising edges becomes one sampling pulse. The frame format is set by static controls:

- 7 or 8 data bits, sent least significant bit first;
- parity off, or even or odd parity;
- one or two stop bits.

Each finished character is copied into a holding register that is separate from the shifter. The next frame can therefore be assembled while the previous character waits to be read. A read strobe tells the receiver that the held character has been taken. Status outputs report ready, parity error, framing error and overrun.

Top module: `serial_rx16`

## Requirements
- R1: A frame starts at a sampling pulse where the synchronized line is low and was high at the previous sampling pulse. The serial input passes through two flip-flops before any decision is made.
- R2: The start bit is checked again at its 8th sampling pulse. If the line is high then, the receiver returns to idle, reports nothing and leaves every output unchanged.
- R3: Every bit of a frame is 16 sampling pulses long, and each bit after the start bit is taken once, at its 8th pulse. Data bits fill `rx_data` starting at bit 0.
- R4: With `len7`=1, seven data bits are received and `rx_data[7]` reads 0.
- R5: With `par_en`=1, one parity bit follows the data. `par_odd`=0 expects an even number of ones over the data and parity bits together, and `par_odd`=1 expects an odd number. A mismatch sets `perr` with the character. With `par_en`=0, `perr` is 0.
- R6: A low level at the 8th pulse of the first stop bit sets `ferr` with the character. The character is complete at that pulse.
- R7: With `stop2`=1, the level of the second stop bit is never checked. No new start can be detected before the 8th pulse of the second stop bit.
- R8: With `use_ext`=1, each rising edge of `ext_clk` is one sampling pulse, and `tick_int` is ignored. With `use_ext`=0, `tick_int` is the sampling pulse.
- R9: A completed character is loaded into `rx_data`, `perr` and `ferr`, and `rdy` is set one cycle after the completing pulse. `rd_ack` clears `rdy` and `ovr`. A character that completes in the same cycle as `rd_ack` is loaded normally.
- R10: If a character completes while `rdy` is 1 and `rd_ack` is 0, `ovr` is set. The new character is discarded, and the held data and flags stay as they were.
- R11: After reset, `rdy`, `perr`, `ferr`, `ovr` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial input line, idle high |
| use_ext | input | 1 | 1 selects the external sampling clock |
| ext_clk | input | 1 | External clock at 16 times the bit rate |
| tick_int | input | 1 | Internal one-cycle sampling pulse |
| len7 | input | 1 | 1 selects seven data bits |
| par_en | input | 1 | 1 enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity |
| stop2 | input | 1 | 1 selects two stop bits |
| rd_ack | input | 1 | Held character has been read |
| rx_data | output | 8 | Held character |
| rdy | output | 1 | Held character is valid |
| perr | output | 1 | Parity error of the held character |
| ferr | output | 1 | Framing error of the held character |
| ovr | output | 1 | A character was lost while one was held |

## Verification
The embedded assertions check four rules on every cycle:

- `ovr` is never set without `rdy`.
- The held data stays frozen while it is unread.
- A read strobe always leaves `ovr` clear.
- A newly loaded character has a zero top bit in 7-bit mode and a clear parity error when parity is off.

Other behaviour can only be shown by the bench's scenarios against its timing model:

- mid-bit sampling;
- rejection of a start glitch;
- parity in both senses and framing errors;
- the unchecked second stop bit;
- overrun with the old character kept;
- correct reception with the external clock selected while the internal pulse keeps running.

// File: rtl/serial_rx16.sv
module serial_rx16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       use_ext,
  input  logic       ext_clk,
  input  logic       tick_int,
  input  logic       len7,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic       rd_ack,
  output logic [7:0] rx_data,
  output logic       rdy,
  output logic       perr,
  output logic       ferr,
  output logic       ovr
);
  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP1, STOP2} st_t;

  st_t        st;
  logic [1:0] rx_sync;
  logic [2:0] ck_sync;
  logic [3:0] cnt;
  logic [2:0] nb;
  logic [7:0] sh;
  logic       prev, acc, pbad;

  logic       rx_s, tick, mid, endb, last_bit, done;
  logic [7:0] word;

  assign rx_s     = rx_sync[1];
  assign tick     = use_ext ? (ck_sync[1] & ~ck_sync[2]) : tick_int;
  assign mid      = tick && (cnt == 4'd7);
  assign endb     = tick && (cnt == 4'd15);
  assign last_bit = (nb == (len7 ? 3'd6 : 3'd7));
  assign done     = mid && (st == STOP1);
  assign word     = len7 ? {1'b0, sh[7:1]} : sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sync <= 2'b11;
      ck_sync <= 3'b000;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      ck_sync <= {ck_sync[1:0], ext_clk};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= 4'd0;
      nb   <= 3'd0;
      sh   <= 8'd0;
      prev <= 1'b0;
      acc  <= 1'b0;
      pbad <= 1'b0;
    end else if (tick) begin
      prev <= rx_s;
      cnt  <= cnt + 4'd1;
      case (st)
        IDLE:  if (prev && !rx_s) begin st <= START; cnt <= 4'd1; end
        START: if (mid && rx_s) st <= IDLE;
               else if (endb) begin st <= DATA; nb <= 3'd0; acc <= 1'b0; pbad <= 1'b0; end
        DATA: begin
          if (mid) begin sh <= {rx_s, sh[7:1]}; acc <= acc ^ rx_s; end
          if (endb) begin
            nb <= nb + 3'd1;
            if (last_bit) st <= par_en ? PAR : STOP1;
          end
        end
        PAR: begin
          if (mid) pbad <= acc ^ rx_s ^ par_odd;
          if (endb) st <= STOP1;
        end
        STOP1: if (mid && !stop2) st <= IDLE;
               else if (endb) st <= STOP2;
        STOP2: if (mid) st <= IDLE;
        default: st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= 8'd0;
      rdy     <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (done && !(rdy && !rd_ack)) begin
        rx_data <= word;
        perr    <= pbad;
        ferr    <= !rx_s;
      end
      if (done) rdy <= 1'b1;
      else if (rd_ack) rdy <= 1'b0;
      if (done && rdy && !rd_ack) ovr <= 1'b1;
      else if (rd_ack) ovr <= 1'b0;
    end

  // R10
  ovr_implies_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n) ovr |-> rdy);
  // R10
  held_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy) && !$past(rd_ack)) |-> $stable(rx_data));
  // R9
  ack_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_ack |=> !ovr);
  // R4
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdy) && $past(len7)) |-> !rx_data[7]);
  // R5
  no_parity_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdy) && !$past(par_en)) |-> !perr);
endmodule

// File: tb/serial_rx16_tb.sv
module serial_rx16_tb;
  logic clk = 0, rst_n = 0, rxd = 1, use_ext = 0, ext_clk = 0, tick_int = 0;
  logic len7 = 0, par_en = 0, par_odd = 0, stop2 = 0, rd_ack = 0;
  logic [7:0] rx_data;
  logic rdy, perr, ferr, ovr;
  int vecs = 0, bad = 0;

  always #4 clk = ~clk;

  serial_rx16 u_dut (.clk(clk), .rst_n(rst_n), .rxd(rxd), .use_ext(use_ext), .ext_clk(ext_clk),
    .tick_int(tick_int), .len7(len7), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .rd_ack(rd_ack), .rx_data(rx_data), .rdy(rdy), .perr(perr), .ferr(ferr), .ovr(ovr));

  int dcnt = 0, ecnt = 0, bt = 0;
  always @(negedge clk) begin
    logic old;
    tick_int = (dcnt == 3);
    dcnt = (dcnt + 1) % 4;
    old = ext_clk;
    ecnt = (ecnt + 1) % 6;
    ext_clk = (ecnt < 3);
    if (use_ext ? (!old && ext_clk) : tick_int) bt++;
  end

  // reference timing model
  logic m_r1, m_r2, m_e1, m_e2, m_e3, m_prev;
  int busy, t;
  int frm[0:15];
  logic [7:0] e_data;
  logic e_rdy, e_perr, e_ferr, e_ovr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 1; m_r2 = 1; m_e1 = 0; m_e2 = 0; m_e3 = 0; m_prev = 0; busy = 0; t = 0;
      e_data = 0; e_rdy = 0; e_perr = 0; e_ferr = 0; e_ovr = 0;
    end else begin
      logic rs, tk, fin, c_perr, c_ferr, load;
      logic [7:0] c_val;
      rs = m_r2;
      tk = use_ext ? (m_e2 && !m_e3) : tick_int;
      fin = 0; c_val = 0; c_perr = 0; c_ferr = 0;
      if (tk) begin
        if (busy == 0) begin
          if (m_prev && !rs) begin busy = 1; t = 1; end
        end else begin
          int b, off, nd, sidx, ones;
          t++;
          b = (t - 1) / 16; off = (t - 1) % 16;
          nd = len7 ? 7 : 8;
          sidx = nd + 1 + (par_en ? 1 : 0);
          if (off == 7) begin
            if (b == 0) begin
              if (rs) busy = 0;
            end else if (b < sidx) frm[b] = int'(rs);
            else if (b == sidx) begin
              fin = 1; ones = 0;
              for (int i = 1; i <= nd; i++) begin
                c_val[i-1] = frm[i][0]; ones += frm[i];
              end
              if (par_en) c_perr = ((ones + frm[nd+1]) % 2) != int'(par_odd);
              c_ferr = !rs;
              if (!stop2) busy = 0;
            end else busy = 0;
          end
        end
        m_prev = rs;
      end
      load = fin && !(e_rdy && !rd_ack);
      if (fin && e_rdy && !rd_ack) e_ovr = 1; else if (rd_ack) e_ovr = 0;
      if (fin) e_rdy = 1; else if (rd_ack) e_rdy = 0;
      if (load) begin e_data = c_val; e_perr = c_perr; e_ferr = c_ferr; end
      m_r2 = m_r1; m_r1 = rxd;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
    end
  end

  always @(posedge clk) begin
    #2;
    vecs++;
    if (rx_data !== e_data || rdy !== e_rdy || perr !== e_perr || ferr !== e_ferr || ovr !== e_ovr) begin
      bad++;
      $display("FAIL R3/R5/R6/R9/R10 model t=%0t: act d=%h r=%b p=%b f=%b o=%b exp d=%h r=%b p=%b f=%b o=%b",
        $time, rx_data, rdy, perr, ferr, ovr, e_data, e_rdy, e_perr, e_ferr, e_ovr);
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int target;
    target = bt + n;
    while (bt < target) @(negedge clk);
  endtask

  task automatic bitl(input logic v);
    rxd = v;
    wait_ticks(16);
  endtask

  task automatic send(input logic [7:0] d, input logic badp, input logic s1, input logic s2);
    logic p;
    int nd;
    nd = len7 ? 7 : 8;
    p = par_odd;
    bitl(0);
    for (int i = 0; i < nd; i++) begin bitl(d[i]); p ^= d[i]; end
    if (par_en) bitl(p ^ badp);
    bitl(s1);
    if (stop2) bitl(s2);
    rxd = 1;
    wait_ticks(24);
  endtask

  task automatic ack();
    @(negedge clk) rd_ack = 1;
    @(negedge clk) rd_ack = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rdy", rdy, 0); chk("R11 ovr", ovr, 0); chk("R11 data", rx_data, 0);
    chk("R11 flags", {perr, ferr}, 0);
    wait_ticks(20);

    send(8'hA5, 0, 1, 1);
    chk("R1 rdy", rdy, 1); chk("R3 data", rx_data, 8'hA5); chk("R6 ferr clean", ferr, 0);
    ack();
    chk("R9 rdy cleared", rdy, 0);

    len7 = 1; par_en = 1; par_odd = 0;
    send(8'h5A, 0, 1, 1);
    chk("R4 data", rx_data, 8'h5A); chk("R5 even ok", perr, 0);
    ack();
    send(8'hFF, 1, 1, 1);
    chk("R4 top zero", rx_data, 8'h7F); chk("R5 even bad", perr, 1);
    ack();
    len7 = 0; par_odd = 1;
    send(8'h37, 0, 1, 1);
    chk("R5 odd ok", perr, 0); chk("R3 data odd", rx_data, 8'h37);
    ack();
    par_en = 0;

    send(8'h0F, 0, 0, 1);
    chk("R6 ferr", ferr, 1); chk("R6 data", rx_data, 8'h0F);
    ack();

    rxd = 0; wait_ticks(4); rxd = 1; wait_ticks(40);
    chk("R2 glitch ignored", rdy, 0); chk("R2 data unchanged", rx_data, 8'h0F);
    send(8'h3C, 0, 1, 1);
    chk("R2 next frame", rx_data, 8'h3C);
    ack();

    stop2 = 1;
    send(8'h81, 0, 1, 0);
    chk("R7 data", rx_data, 8'h81); chk("R7 second stop unchecked", ferr, 0);
    ack();
    wait_ticks(60);
    chk("R7 no spurious start", rdy, 0);
    stop2 = 0;

    send(8'h11, 0, 1, 1);
    send(8'h22, 0, 1, 1);
    chk("R10 ovr", ovr, 1); chk("R10 old data kept", rx_data, 8'h11);
    ack();
    chk("R9 ovr cleared", ovr, 0); chk("R9 rdy cleared", rdy, 0);

    use_ext = 1;
    wait_ticks(20);
    send(8'h96, 0, 1, 1);
    chk("R8 ext data", rx_data, 8'h96); chk("R8 ext rdy", rdy, 1);
    ack();
    use_ext = 0;
    wait_ticks(20);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule